// File: doc/BRIEF.md
# Inbound DMA Address Window Translator

This block sits on the upstream path of an I/O bridge. Downstream devices issue DMA requests carrying 64-bit bus addresses. The block turns each address into a 54-bit system fabric address and two attribute flags: barrier and MSI. It first sorts the address into one of five windows.

Two of the windows are direct mappings. The 64-bit direct window passes the low fabric bits through unchanged. The 32-bit direct window joins the low 30 address bits to a per-port upper-bits register.

The other three windows look up page-translation entries:
- A shared table is used with 256 KB pages by the 32-bit mapped window.
- The same shared table is used with 16 GB pages by the 40-bit super-page window, whose low 64 entries are split between the two ports.
- A separate table is used with 64 MB pages by the 40-bit mapped window.

Software loads both tables and the two direct-map registers through a single write port. A request that cannot be translated raises a fault flag. The lookup is a two-stage pipeline that accepts one request every cycle.

Top module: `ibx_window_xlate`

## Requirements
- R1: An address with bit 63 set is translated directly. The fabric address is address bits 53:0, the barrier flag is address bit 62 and the MSI flag is address bit 61.
- R2: In the 64-bit direct window, any set bit among address bits 60:54 faults the request.
- R3: Addresses 0x8000_0000 to 0xFFFF_FFFF are translated directly through the direct-map register of `req_port`. The fabric address is {register bits 23:0, address bits 29:0}, the barrier flag is address bit 30, and the MSI flag is always 0.
- R4: Addresses 0x0 to 0x7FFF_FFFF use shared-table entry address[29:18]. The fabric address is the entry base (entry bits 53:18) with address[17:0] appended. The barrier flag is address bit 30 and the MSI flag is entry bit 62.
- R5: In the 32-bit mapped window, an entry index below 64 or not below SH_ENTRIES faults.
- R6: Addresses 0x40_0000_0000 to 0x7F_FFFF_FFFF use 40-bit table entry address[37:26], with an index of M40_ENTRIES or above faulting. The fabric address is entry bits 53:26 with address[25:0]. Barrier and MSI are 0.
- R7: Addresses 0x80_0000_0000 to 0xFF_FFFF_FFFF use shared-table entry req_port*32 + address[38:34]. The fabric address is entry bits 53:34 with address[33:0]. Barrier and MSI are 0.
- R8: A mapped-window lookup that hits an entry with bit 63 (valid) clear faults.
- R9: An address with bit 63 clear that lies in none of the four low windows faults.
- R10: A faulted response carries address 0, barrier 0 and MSI 0.
- R11: Every accepted request produces exactly one response with `rsp_valid` exactly two cycles later, in order, with back-to-back requests allowed. No response appears otherwise.
- R12: After reset all table entries are invalid, both direct-map registers are zero and `rsp_valid` is low.
- R13: The write port decodes `wr_sel` as follows:
  - 0 writes shared entry `wr_idx`.
  - 1 writes 40-bit entry `wr_idx` when `wr_idx` is below M40_ENTRIES.
  - 2 loads direct-map register `wr_idx` (0 or 1) from `wr_data[53:30]`.
  - 3, and out-of-range indices, change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Configuration write strobe |
| wr_sel | input | 2 | Write target: 0 shared table, 1 40-bit table, 2 direct-map register |
| wr_idx | input | $clog2(SH_ENTRIES) | Entry or port index of the write |
| wr_data | input | 64 | Entry value or direct-map value |
| req_valid | input | 1 | Lookup request valid |
| req_port | input | 1 | Requesting port (0 or 1) |
| req_addr | input | 64 | Inbound bus address |
| rsp_valid | output | 1 | Result valid, two cycles after the request |
| rsp_addr | output | 54 | Translated fabric address |
| rsp_barrier | output | 1 | Barrier attribute |
| rsp_msi | output | 1 | MSI attribute |
| rsp_fault | output | 1 | Translation failed |

## Verification
A corrupted table entry or direct-map register shows up in the result of the next lookup that reaches it, either as a wrong fabric base or as a wrong MSI or fault flag. It appears exactly two cycles after that request, and nothing shows before software or traffic touches the entry. A misclassified window shows up in the same response:
- as a barrier or MSI flag where the window allows none,
- as the wrong page boundary inside the fabric address,
- as a fault where a translation was expected, or the reverse.

A broken pipeline register shifts or drops `rsp_valid` relative to the request stream, which is visible on the very next request.

// File: rtl/ibx_pkg.sv
package ibx_pkg;
  localparam int FAB_W    = 54;  // fabric address width
  localparam int PS_M32   = 18;  // 256 KB page shift
  localparam int PS_M40   = 26;  // 64 MB page shift
  localparam int PS_SUP   = 34;  // 16 GB page shift
  localparam int RSV_LOW  = 64;  // shared entries kept for super pages
  localparam int DIR_W    = FAB_W - 30;

  typedef enum logic [2:0] {
    WIN_NONE, WIN_D64, WIN_D32, WIN_M32, WIN_M40, WIN_SUP
  } win_e;

  typedef struct packed {
    win_e        win;
    logic        pre_fault;
    logic        port;
    logic [15:0] tidx;
    logic [63:0] addr;
  } req_t;

  // Keep the page-aligned part of the entry, take the in-page offset from the address.
  function automatic logic [FAB_W-1:0] splice(input logic [63:0] ent,
                                              input logic [63:0] addr,
                                              input int sh);
    logic [FAB_W-1:0] mask;
    mask = (FAB_W'(1) << sh) - FAB_W'(1);
    return (ent[FAB_W-1:0] & ~mask) | (addr[FAB_W-1:0] & mask);
  endfunction
endpackage

// File: rtl/ibx_classify.sv
module ibx_classify
  import ibx_pkg::*;
#(
  parameter int SH_ENTRIES  = 128,
  parameter int M40_ENTRIES = 64
) (
  input  logic [63:0] addr,
  input  logic        port,
  output win_e        win,
  output logic [15:0] tidx,
  output logic        pre_fault
);
  always_comb begin
    win       = WIN_NONE;
    tidx      = '0;
    pre_fault = 1'b0;
    if (addr[63]) begin
      win       = WIN_D64;
      pre_fault = |addr[60:54];
    end else if (addr[62:32] == '0 && addr[31]) begin
      win = WIN_D32;
    end else if (addr[62:31] == '0) begin
      win       = WIN_M32;
      tidx      = 16'(addr[29:18]);
      pre_fault = (tidx < 16'(RSV_LOW)) || (tidx >= 16'(SH_ENTRIES));
    end else if (addr[62:39] == '0 && addr[38]) begin
      win       = WIN_M40;
      tidx      = 16'(addr[37:26]);
      pre_fault = tidx >= 16'(M40_ENTRIES);
    end else if (addr[62:40] == '0 && addr[39]) begin
      win  = WIN_SUP;
      tidx = 16'({port, addr[38:34]});
    end
    if (win == WIN_NONE) pre_fault = 1'b1;
  end
endmodule

// File: rtl/ibx_entry_table.sv
module ibx_entry_table #(
  parameter int DEPTH = 64,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [IW-1:0] widx,
  input  logic [63:0]   wdata,
  input  logic [IW-1:0] ridx,
  output logic [63:0]   rdata
);
  logic [63:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[widx] <= wdata;
    end
  end

  assign rdata = mem[ridx];

  // R13: a write is visible at its index on the next cycle
  assert_write_lands_R13: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> mem[$past(widx)] == $past(wdata));
endmodule

// File: rtl/ibx_window_xlate.sv
module ibx_window_xlate
  import ibx_pkg::*;
#(
  parameter int SH_ENTRIES  = 128,
  parameter int M40_ENTRIES = 64,
  localparam int WR_IW      = $clog2(SH_ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [WR_IW-1:0] wr_idx,
  input  logic [63:0]      wr_data,
  input  logic             req_valid,
  input  logic             req_port,
  input  logic [63:0]      req_addr,
  output logic             rsp_valid,
  output logic [FAB_W-1:0] rsp_addr,
  output logic             rsp_barrier,
  output logic             rsp_msi,
  output logic             rsp_fault
);
  localparam int SH_IW  = $clog2(SH_ENTRIES);
  localparam int M40_IW = $clog2(M40_ENTRIES);

  // ---------------- configuration writes ----------------
  logic            sh_we, m40_we;
  logic [DIR_W-1:0] dir_q [2];

  assign sh_we  = wr_en && wr_sel == 2'd0;
  assign m40_we = wr_en && wr_sel == 2'd1 && int'(wr_idx) < M40_ENTRIES;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_q[0] <= '0;
      dir_q[1] <= '0;
    end else if (wr_en && wr_sel == 2'd2 && int'(wr_idx) < 2) begin
      dir_q[wr_idx[0]] <= wr_data[FAB_W-1:30];
    end
  end

  // ---------------- stage 1: classify ----------------
  win_e        c_win;
  logic [15:0] c_tidx;
  logic        c_pre_fault;
  req_t        s1_q;
  logic        s1_v;

  ibx_classify #(.SH_ENTRIES(SH_ENTRIES), .M40_ENTRIES(M40_ENTRIES)) u_cls (
    .addr(req_addr), .port(req_port),
    .win(c_win), .tidx(c_tidx), .pre_fault(c_pre_fault));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_v <= 1'b0;
      s1_q <= '0;
    end else begin
      s1_v <= req_valid;
      s1_q <= '{win: c_win, pre_fault: c_pre_fault, port: req_port,
                tidx: c_tidx, addr: req_addr};
    end
  end

  // ---------------- tables ----------------
  logic [63:0] sh_rd, m40_rd;

  ibx_entry_table #(.DEPTH(SH_ENTRIES)) u_sh (
    .clk(clk), .rst_n(rst_n), .we(sh_we), .widx(wr_idx[SH_IW-1:0]),
    .wdata(wr_data), .ridx(s1_q.tidx[SH_IW-1:0]), .rdata(sh_rd));

  ibx_entry_table #(.DEPTH(M40_ENTRIES)) u_m40 (
    .clk(clk), .rst_n(rst_n), .we(m40_we), .widx(wr_idx[M40_IW-1:0]),
    .wdata(wr_data), .ridx(s1_q.tidx[M40_IW-1:0]), .rdata(m40_rd));

  // ---------------- stage 2: translate ----------------
  logic [63:0]      ent;
  logic             mapped, miss, fault_n;
  logic [FAB_W-1:0] x_addr;
  logic             x_bar, x_msi;

  assign ent    = (s1_q.win == WIN_M40) ? m40_rd : sh_rd;
  assign mapped = s1_q.win inside {WIN_M32, WIN_M40, WIN_SUP};
  assign miss   = mapped && !ent[63];
  assign fault_n = s1_q.pre_fault || miss;

  always_comb begin
    x_addr = '0;
    x_bar  = 1'b0;
    x_msi  = 1'b0;
    unique case (s1_q.win)
      WIN_D64: begin
        x_addr = s1_q.addr[FAB_W-1:0];
        x_bar  = s1_q.addr[62];
        x_msi  = s1_q.addr[61];
      end
      WIN_D32: begin
        x_addr = {dir_q[s1_q.port], s1_q.addr[29:0]};
        x_bar  = s1_q.addr[30];
      end
      WIN_M32: begin
        x_addr = splice(ent, s1_q.addr, PS_M32);
        x_bar  = s1_q.addr[30];
        x_msi  = ent[62];
      end
      WIN_M40: x_addr = splice(ent, s1_q.addr, PS_M40);
      WIN_SUP: x_addr = splice(ent, s1_q.addr, PS_SUP);
      default: ;
    endcase
    if (fault_n) begin
      x_addr = '0;
      x_bar  = 1'b0;
      x_msi  = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid   <= 1'b0;
      rsp_addr    <= '0;
      rsp_barrier <= 1'b0;
      rsp_msi     <= 1'b0;
      rsp_fault   <= 1'b0;
    end else begin
      rsp_valid   <= s1_v;
      rsp_addr    <= x_addr;
      rsp_barrier <= x_bar;
      rsp_msi     <= x_msi;
      rsp_fault   <= fault_n;
    end
  end

  // ---------------- assertions ----------------
  // R11: fixed two-cycle latency, one response per request
  assert_latency_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid == $past(req_valid, 2));

  // R1: clean direct 64-bit request never faults and carries its attribute bits
  assert_d64_attr_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(req_valid && req_addr >= 64'h8000_0000_0000_0000 && req_addr[60:54] == 7'd0, 2)
    |-> !rsp_fault && rsp_barrier == $past(req_addr[62], 2) && rsp_msi == $past(req_addr[61], 2));

  // R2: reserved bits in direct 64-bit mode fault
  assert_d64_rsv_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(req_valid && req_addr[63] && req_addr[60:54] != 7'd0, 2) |-> rsp_fault);

  // R3: direct 32-bit keeps the low offset and never signals MSI
  assert_d32_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(req_valid && req_addr >= 64'h8000_0000 && req_addr <= 64'hFFFF_FFFF, 2)
    |-> !rsp_fault && !rsp_msi && rsp_addr[29:0] == $past(req_addr[29:0], 2));

  // R5: super-page region of the shared table is unreachable from the 32-bit mapped window
  assert_m32_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(req_valid && req_addr < 64'h8000_0000 && req_addr[29:0] < 30'(RSV_LOW << PS_M32), 2)
    |-> rsp_fault);

  // R6 / R7: 40-bit windows carry no attributes
  assert_m40_noattr_R6_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(req_valid && req_addr >= 64'h40_0000_0000 && req_addr <= 64'hFF_FFFF_FFFF, 2)
    |-> !rsp_barrier && !rsp_msi);

  // R9: holes between windows fault
  assert_hole_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(req_valid && !req_addr[63] && ((req_addr > 64'hFFFF_FFFF && req_addr < 64'h40_0000_0000)
          || req_addr > 64'hFF_FFFF_FFFF), 2) |-> rsp_fault);

  // R10: faulted responses are clean
  assert_fault_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault |-> rsp_addr == '0 && !rsp_barrier && !rsp_msi);
endmodule

// File: tb/ibx_window_xlate_test.sv
module ibx_window_xlate_test;
  localparam int SH  = 128;
  localparam int M40 = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic [6:0]  wr_idx = '0;
  logic [63:0] wr_data = '0;
  logic        req_valid = 1'b0;
  logic        req_port = 1'b0;
  logic [63:0] req_addr = '0;
  logic        rsp_valid, rsp_barrier, rsp_msi, rsp_fault;
  logic [53:0] rsp_addr;

  always #5 clk = ~clk;

  ibx_window_xlate #(.SH_ENTRIES(SH), .M40_ENTRIES(M40)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_idx(wr_idx),
    .wr_data(wr_data), .req_valid(req_valid), .req_port(req_port), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .rsp_barrier(rsp_barrier),
    .rsp_msi(rsp_msi), .rsp_fault(rsp_fault));

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // bench-side shadow of the configuration state
  logic [63:0] sh_m  [SH];
  logic [63:0] m40_m [M40];
  logic [63:0] dir_m [2];

  // expected-response pipeline
  logic        pv [2];
  logic [53:0] pa [2];
  logic        pb [2], pm [2], pf [2];
  string       pt [2];

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic expect_of(input logic [63:0] a, input logic p,
                           output logic [53:0] ea, output logic eb, output logic em,
                           output logic ef, output string tag);
    logic [63:0] off, e, ps, idx, basev;
    ea = '0; eb = 0; em = 0; ef = 0; tag = "R9";
    if (a >= 64'h8000_0000_0000_0000) begin
      tag = "R1";
      if (((a >> 54) & 64'h7f) != 0) begin ef = 1; tag = "R2"; end
      else begin ea = 54'(a % (64'd1 << 54)); eb = (a >> 62) & 1; em = (a >> 61) & 1; end
    end else if (a >= 64'h8000_0000 && a <= 64'hFFFF_FFFF) begin
      tag = "R3";
      ea = 54'(dir_m[p] * (64'd1 << 30) + a % (64'd1 << 30));
      eb = (a >> 30) & 1;
    end else if (a <= 64'h7FFF_FFFF) begin
      tag = "R4";
      ps  = 64'd1 << 18;
      off = a & ~(64'd1 << 30);
      idx = off / ps;
      if (idx < 64 || idx >= SH) begin ef = 1; tag = "R5"; end
      else begin
        e = sh_m[idx];
        if (!e[63]) begin ef = 1; tag = "R8"; end
        else begin
          basev = e % (64'd1 << 54);
          ea = 54'(basev - basev % ps + off % ps);
          eb = (a >> 30) & 1; em = e[62];
        end
      end
    end else if (a >= 64'h40_0000_0000 && a <= 64'h7F_FFFF_FFFF) begin
      tag = "R6";
      ps  = 64'd1 << 26;
      off = a - 64'h40_0000_0000;
      idx = off / ps;
      if (idx >= M40) ef = 1;
      else begin
        e = m40_m[idx];
        if (!e[63]) begin ef = 1; tag = "R8"; end
        else begin basev = e % (64'd1 << 54); ea = 54'(basev - basev % ps + off % ps); end
      end
    end else if (a >= 64'h80_0000_0000 && a <= 64'hFF_FFFF_FFFF) begin
      tag = "R7";
      ps  = 64'd1 << 34;
      off = a - 64'h80_0000_0000;
      idx = 32 * p + off / ps;
      e   = sh_m[idx];
      if (!e[63]) begin ef = 1; tag = "R8"; end
      else begin basev = e % (64'd1 << 54); ea = 54'(basev - basev % ps + off % ps); end
    end else begin
      ef = 1;
    end
  endtask

  // One cycle: check the response due now, then drive the next request.
  task automatic tick(input logic v, input logic [63:0] a, input logic p, input string tover);
    logic [53:0] ea; logic eb, em, ef; string tag;
    @(negedge clk);
    checks++;
    if (pv[1]) begin
      if (rsp_valid !== 1'b1 || rsp_fault !== pf[1] || rsp_addr !== pa[1] ||
          rsp_barrier !== pb[1] || rsp_msi !== pm[1]) begin
        errors++;
        $display("FAIL %s (R10/R11): actual v=%b f=%b a=%h b=%b m=%b expected v=1 f=%b a=%h b=%b m=%b",
                 pt[1], rsp_valid, rsp_fault, rsp_addr, rsp_barrier, rsp_msi,
                 pf[1], pa[1], pb[1], pm[1]);
      end
    end else if (rsp_valid !== 1'b0) begin
      errors++;
      $display("FAIL R11: actual rsp_valid=%b expected 0", rsp_valid);
    end
    pv[1] = pv[0]; pa[1] = pa[0]; pb[1] = pb[0]; pm[1] = pm[0]; pf[1] = pf[0]; pt[1] = pt[0];
    expect_of(a, p, ea, eb, em, ef, tag);
    pv[0] = v; pa[0] = ea; pb[0] = eb; pm[0] = em; pf[0] = ef;
    pt[0] = (tover.len() != 0) ? tover : tag;
    req_valid = v; req_addr = a; req_port = p;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick(1'b0, 64'd0, 1'b0, "");
  endtask

  // R13 write port with bench shadow update
  task automatic cfg_write(input logic [1:0] s, input logic [6:0] i, input logic [63:0] d);
    @(negedge clk);
    wr_en = 1; wr_sel = s; wr_idx = i; wr_data = d;
    if (s == 0) sh_m[i] = d;
    else if (s == 1 && i < M40) m40_m[i] = d;
    else if (s == 2 && i < 2) dir_m[i] = (d >> 30) % (64'd1 << 24);
    @(negedge clk);
    wr_en = 0;
  endtask

  function automatic logic [63:0] rnd64();
    return {$urandom, $urandom};
  endfunction

  function automatic logic [63:0] rnd_entry();
    logic [63:0] e;
    e = rnd64() % (64'd1 << 54);
    e[63] = ($urandom % 4) != 0;
    e[62] = $urandom % 2;
    return e;
  endfunction

  function automatic logic [63:0] rnd_addr();
    logic [63:0] a;
    int k;
    k = $urandom % 7;
    case (k)
      0: begin
        a = rnd64();
        a[63] = 1;
        if ($urandom % 8 != 0) a[60:54] = '0;
      end
      1: a = 64'h8000_0000 + 64'($urandom % 32'h8000_0000);
      2, 6: a = (64'(60 + $urandom % 75) << 18) + 64'($urandom % (1 << 18))
                + (64'($urandom % 2) << 30);
      3: a = 64'h40_0000_0000 + (64'($urandom % 70) << 26) + 64'($urandom % (1 << 26));
      4: a = 64'h80_0000_0000 + (rnd64() % (64'd1 << 39));
      default: a = ($urandom % 2 != 0) ? 64'h1_0000_0000 + 64'($urandom)
                                       : 64'h100_0000_0000 + rnd64() % (64'd1 << 62);
    endcase
    return a;
  endfunction

  initial begin
    void'($urandom(32'd20250611));
    for (int i = 0; i < SH; i++) sh_m[i] = '0;
    for (int i = 0; i < M40; i++) m40_m[i] = '0;
    dir_m[0] = '0; dir_m[1] = '0;
    for (int i = 0; i < 2; i++) begin pv[i] = 0; pa[i] = '0; pb[i] = 0; pm[i] = 0; pf[i] = 0; pt[i] = ""; end

    repeat (3) @(negedge clk);
    rst_n = 1;

    // R12: reset state seen at the ports
    @(negedge clk);
    checks++;
    if (rsp_valid !== 1'b0) begin
      errors++;
      $display("FAIL R12: actual rsp_valid=%b expected 0", rsp_valid);
    end
    tick(1, 64'h0100_0000, 0, "R12");      // shared entry 64, invalid after reset
    tick(1, 64'h40_0000_0000, 1, "R12");   // 40-bit entry 0, invalid after reset
    tick(1, 64'hC123_4567, 1, "R12");      // direct-map register still zero
    idle(3);

    // load configuration (R13)
    for (int i = 0; i < SH; i++) cfg_write(2'd0, 7'(i), rnd_entry());
    for (int i = 0; i < M40; i++) cfg_write(2'd1, 7'(i), rnd_entry());
    cfg_write(2'd2, 7'd0, rnd64());
    cfg_write(2'd2, 7'd1, rnd64());
    // known entries for directed cases
    cfg_write(2'd0, 7'd64, 64'hC000_0000_ABCC_0000);   // valid, msi-capable
    cfg_write(2'd0, 7'd65, 64'h0000_0000_1234_0000);   // invalid
    cfg_write(2'd0, 7'd63, 64'h8000_0012_3400_0000);   // port 1 super slot 31
    cfg_write(2'd1, 7'd36, 64'h8000_0000_4C00_0000);
    // R13: ignored writes
    cfg_write(2'd1, 7'd100, 64'h8000_0000_FC00_0000);  // beyond 40-bit table
    cfg_write(2'd3, 7'd36, 64'h8000_0000_0400_0000);   // unused selector
    cfg_write(2'd2, 7'd5, 64'hFFFF_FFFF_FFFF_FFFF);    // no such port
    idle(2);

    // directed corner cases
    tick(1, 64'hE000_0000_0000_1234, 0, "R1");
    tick(1, 64'h8040_0000_0000_0000, 0, "R2");
    tick(1, 64'hFFFF_FFFF, 0, "R3");
    tick(1, 64'h8000_0000, 1, "R3");
    tick(1, 64'h4100_0000 + 64'h3_FFFF, 0, "R4");      // idx 64, barrier set
    tick(1, 64'h00FC_0000, 0, "R5");                   // idx 63
    tick(1, 64'h0200_0000, 0, "R5");                   // idx 128
    tick(1, 64'h0104_0000, 0, "R8");                   // idx 65 invalid
    tick(1, 64'h40_0000_0000 + (64'd36 << 26) + 64'h123, 0, "R13");
    tick(1, 64'h40_0000_0000 + (64'd64 << 26), 0, "R6");
    tick(1, 64'hFF_FFFF_FFFF, 1, "R7");                // port 1 slot 31 -> entry 63
    tick(1, 64'h1_0000_0000, 0, "R9");
    tick(1, 64'h100_0000_0000, 0, "R9");
    idle(2);

    // random stream with gaps, both ports
    for (int n = 0; n < 3000; n++) begin
      if ($urandom % 5 == 0) tick(0, 64'd0, 0, "");
      else tick(1, rnd_addr(), 1'($urandom % 2), "");
    end
    idle(3);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule